// File: doc/BRIEF.md
# PHY Identify and Bring-Up Sequencer

This block brings an attached Ethernet PHY into service over its management bus with no software involvement. On `start` it reads the PHY's two identifier registers and joins them into a 32-bit identity. It compares that identity with a small table of known PHY types. It then runs the matched type's configuration list, followed by its startup list. Each list entry is a constant write, a read whose result is decoded, a read that is thrown away, or an end marker. The decoded link state, speed and duplex are held on status outputs until the next run.

The block has no serial timing of its own. It talks to a simple management master through a request/acknowledge handshake. Before each list it also gives the master a reset pulse, then an init pulse, and waits until the master's busy flag drops.

States and transitions: `ST_IDLE` goes to `ST_ID_HI` on `start`. `ST_ID_HI` goes to `ST_ID_LO` on ack, and `ST_ID_LO` goes to `ST_MATCH` on ack. `ST_MATCH` goes to `ST_PORT_RST` on a table hit, or back to `ST_IDLE` with `unsupported` set. `ST_PORT_RST` goes to `ST_PORT_INIT`, then to `ST_WAIT_BUSY`, which leaves for `ST_FETCH` once busy is low. From `ST_FETCH` a non-end entry goes to `ST_XFER`. An end entry goes to `ST_PORT_RST` if the config list just finished, or to `ST_DONE` if the startup list did. `ST_XFER` returns to `ST_FETCH` on ack, and `ST_DONE` returns to `ST_IDLE`.

Top module: `mdio_phy_sequencer`

## Requirements
- R1: After `start`, the first two transactions are reads of register 2 and then register 3. The identity is {reg2 value, reg3 value}, with reg2 in bits 31:16.
- R2: Table entry i matches when (identity >> shift_i) == id_i. The entries are: type 0, id 32'h004A5B3C, shift 4; type 1, id 32'h0000C0FF, shift 6; type 2 (generic), id 0, shift 32, which matches any identity. When several entries match, the lowest index wins.
- R3: With the generic entry disabled (`GENERIC_EN`=0) and no match, `unsupported` goes high and stays high until the next `start`. No list runs, no config pulse is given, no further transaction is made and `done` never pulses.
- R4: Before each list, `mgmt_cfg_reset` is high for one cycle and `mgmt_cfg_init` is high for the following cycle. No request is made while `mgmt_busy` is high after that. Each successful run gives exactly two reset pulses.
- R5: `mdio_req` stays high with `mdio_rw`, `mdio_reg_addr` and `mdio_wdata` stable until `mdio_ack`. Each ack completes one transaction. `mdio_rw`=1 means a read, and reads drive `mdio_wdata`=0.
- R6: The config lists are as follows. Type 0 writes reg 0 = 16'h8000, reg 16 = 16'h0060, then reg 0 = 16'h1200. Type 1 writes reg 0 = 16'h1200. Type 2 writes reg 0 = 16'h8000, then reg 0 = 16'h1200 (auto-negotiation enable plus restart).
- R7: The startup list reads reg 1 twice. The first value is discarded, and `link_up` takes bit 2 of the later parsed read. Types 0 and 1 then read reg 17. Type 2 reads reg 1 a third time and parses that value too.
- R8: The reg 17 decode uses bits 15:14: 00 means 10 half, 01 means 10 full, 10 means 100 half, 11 means 100 full. The `speed` output is 00 for none, 01 for 10 Mb/s and 10 for 100 Mb/s, and `full_duplex`=1 means full.
- R9: While the link is down, `speed` is 00 and `full_duplex` is 0, whatever reg 17 holds.
- R10: The generic type never sets `speed` or `full_duplex`; they stay at 00 and 0.
- R11: `done` is a single-cycle pulse after the startup end marker. The status outputs hold their values after it. `start` clears `link_up`, `speed`, `full_duplex` and `unsupported` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin identify and bring-up (accepted in idle) |
| mgmt_cfg_reset | output | 1 | Pulse that puts the management master's configuration into reset |
| mgmt_cfg_init | output | 1 | Pulse that loads the management master's init configuration |
| mgmt_busy | input | 1 | Management master busy |
| mdio_req | output | 1 | Transaction request, held until ack |
| mdio_rw | output | 1 | 1 = read, 0 = write |
| mdio_reg_addr | output | 5 | PHY register address |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Transaction complete |
| mdio_rdata | input | 16 | Read data, valid with ack |
| done | output | 1 | One-cycle pulse when the startup list ends |
| unsupported | output | 1 | No table entry matched |
| link_up | output | 1 | Decoded link state |
| speed | output | 2 | 00 none, 01 10 Mb/s, 10 100 Mb/s |
| full_duplex | output | 1 | Decoded duplex |

## Verification
The hardest behaviour to reach is the discarded first status read. It only shows up when the PHY returns a different link bit on the first and second reads of register 1. The bench's PHY model therefore returns a stale value on the first read and the live value on later reads, and the two are swapped between cases. Priority and near-miss matching need identities that hit two entries, or that miss a vendor entry by one bit. The no-match path can only be reached with the fallback removed, so a second instance built with `GENERIC_EN`=0 is used for it.

// File: rtl/mdio_seq_pkg.sv
package mdio_seq_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int NUM_TYPES = 3;
    localparam int TYPE_W    = $clog2(NUM_TYPES);
    localparam int STEP_W    = 3;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT  = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ID_HI = 5'd2;
    localparam logic [ADDR_W-1:0] REG_ID_LO = 5'd3;
    localparam logic [ADDR_W-1:0] REG_VTUNE = 5'd16;
    localparam logic [ADDR_W-1:0] REG_VSTAT = 5'd17;

    localparam int STAT_LINK_BIT = 2;
    localparam int VSPD_HI       = 15;
    localparam int VSPD_LO       = 14;

    localparam logic [1:0] SPD_NONE = 2'b00;
    localparam logic [1:0] SPD_10   = 2'b01;
    localparam logic [1:0] SPD_100  = 2'b10;

    typedef enum logic [2:0] {
        CK_WRITE,
        CK_READ_DROP,
        CK_READ_LINK,
        CK_READ_VSTAT,
        CK_END
    } cmd_kind_e;

    typedef enum logic {
        PH_CONFIG,
        PH_STARTUP
    } list_phase_e;

    typedef struct packed {
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] reg_addr;
        logic [DATA_W-1:0] data;
    } phy_cmd_t;

    function automatic logic [31:0] type_id(input int idx);
        case (idx)
            0:       return 32'h004A_5B3C;
            1:       return 32'h0000_C0FF;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic int type_shift(input int idx);
        case (idx)
            0:       return 4;
            1:       return 6;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/phy_id_matcher.sv
module phy_id_matcher
    import mdio_seq_pkg::*;
#(
    parameter bit GENERIC_EN = 1'b1
) (
    input  logic [31:0]       phy_id,
    output logic              hit,
    output logic [TYPE_W-1:0] type_idx
);
    logic [NUM_TYPES-1:0] match;

    for (genvar i = 0; i < NUM_TYPES; i++) begin : g_entry
        if (i == NUM_TYPES - 1 && !GENERIC_EN) begin : g_off
            assign match[i] = 1'b0;
        end else begin : g_on
            logic [63:0] shifted;
            assign shifted  = {32'h0, phy_id} >> type_shift(i);
            assign match[i] = (shifted == {32'h0, type_id(i)});
        end
    end

    always_comb begin
        hit      = |match;
        type_idx = '0;
        for (int i = NUM_TYPES - 1; i >= 0; i--) begin
            if (match[i]) type_idx = TYPE_W'(i);
        end
    end
endmodule

// File: rtl/phy_cmd_rom.sv
module phy_cmd_rom
    import mdio_seq_pkg::*;
(
    input  logic [TYPE_W-1:0] type_idx,
    input  list_phase_e       phase,
    input  logic [STEP_W-1:0] step,
    output phy_cmd_t          cmd
);
    function automatic phy_cmd_t mk(input cmd_kind_e k, input logic [ADDR_W-1:0] a,
                                    input logic [DATA_W-1:0] d);
        phy_cmd_t c;
        c.kind     = k;
        c.reg_addr = a;
        c.data     = d;
        return c;
    endfunction

    always_comb begin
        cmd = mk(CK_END, '0, '0);
        if (phase == PH_CONFIG) begin
            case (type_idx)
                TYPE_W'(0): case (step)
                    3'd0:    cmd = mk(CK_WRITE, REG_CTRL,  16'h8000);
                    3'd1:    cmd = mk(CK_WRITE, REG_VTUNE, 16'h0060);
                    3'd2:    cmd = mk(CK_WRITE, REG_CTRL,  16'h1200);
                    default: cmd = mk(CK_END, '0, '0);
                endcase
                TYPE_W'(1): case (step)
                    3'd0:    cmd = mk(CK_WRITE, REG_CTRL,  16'h1200);
                    default: cmd = mk(CK_END, '0, '0);
                endcase
                default: case (step)
                    3'd0:    cmd = mk(CK_WRITE, REG_CTRL,  16'h8000);
                    3'd1:    cmd = mk(CK_WRITE, REG_CTRL,  16'h1200);
                    default: cmd = mk(CK_END, '0, '0);
                endcase
            endcase
        end else begin
            case (step)
                3'd0:    cmd = mk(CK_READ_DROP, REG_STAT, '0);
                3'd1:    cmd = mk(CK_READ_LINK, REG_STAT, '0);
                3'd2:    cmd = (type_idx == TYPE_W'(NUM_TYPES - 1))
                               ? mk(CK_READ_LINK, REG_STAT, '0)
                               : mk(CK_READ_VSTAT, REG_VSTAT, '0);
                default: cmd = mk(CK_END, '0, '0);
            endcase
        end
    end
endmodule

// File: rtl/phy_status_decoder.sv
module phy_status_decoder
    import mdio_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       ld_link,
    input  logic       link_bit,
    input  logic       ld_vstat,
    input  logic [1:0] vspd,
    output logic       link_up,
    output logic [1:0] speed,
    output logic       full_duplex
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            link_up     <= 1'b0;
            speed       <= SPD_NONE;
            full_duplex <= 1'b0;
        end else if (ld_link) begin
            link_up <= link_bit;
            if (!link_bit) begin
                speed       <= SPD_NONE;
                full_duplex <= 1'b0;
            end
        end else if (ld_vstat) begin
            if (!link_up) begin
                speed       <= SPD_NONE;
                full_duplex <= 1'b0;
            end else begin
                speed       <= vspd[1] ? SPD_100 : SPD_10;
                full_duplex <= vspd[0];
            end
        end
    end

    // R9: a down link never reports a speed or full duplex
    p_linkdown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> (speed == SPD_NONE && !full_duplex));

    // R11: start clears the decoded status
    p_clear_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!link_up && speed == SPD_NONE && !full_duplex));
endmodule

// File: rtl/mdio_phy_sequencer.sv
module mdio_phy_sequencer
    import mdio_seq_pkg::*;
#(
    parameter bit GENERIC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mgmt_cfg_reset,
    output logic              mgmt_cfg_init,
    input  logic              mgmt_busy,
    output logic              mdio_req,
    output logic              mdio_rw,
    output logic [ADDR_W-1:0] mdio_reg_addr,
    output logic [DATA_W-1:0] mdio_wdata,
    input  logic              mdio_ack,
    input  logic [DATA_W-1:0] mdio_rdata,
    output logic              done,
    output logic              unsupported,
    output logic              link_up,
    output logic [1:0]        speed,
    output logic              full_duplex
);
    typedef enum logic [3:0] {
        ST_IDLE, ST_ID_HI, ST_ID_LO, ST_MATCH, ST_PORT_RST,
        ST_PORT_INIT, ST_WAIT_BUSY, ST_FETCH, ST_XFER, ST_DONE
    } state_e;

    state_e            state, state_nx;
    logic [DATA_W-1:0] id_hi, id_lo;
    logic [TYPE_W-1:0] type_q, type_hit;
    logic              hit;
    list_phase_e       phase;
    logic [STEP_W-1:0] step;
    phy_cmd_t          cmd;
    logic              clear, ld_link, ld_vstat;

    phy_id_matcher #(.GENERIC_EN(GENERIC_EN)) u_match (
        .phy_id   ({id_hi, id_lo}),
        .hit      (hit),
        .type_idx (type_hit)
    );

    phy_cmd_rom u_rom (
        .type_idx (type_q),
        .phase    (phase),
        .step     (step),
        .cmd      (cmd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_ID_HI;
            ST_ID_HI:     if (mdio_ack) state_nx = ST_ID_LO;
            ST_ID_LO:     if (mdio_ack) state_nx = ST_MATCH;
            ST_MATCH:     state_nx = hit ? ST_PORT_RST : ST_IDLE;
            ST_PORT_RST:  state_nx = ST_PORT_INIT;
            ST_PORT_INIT: state_nx = ST_WAIT_BUSY;
            ST_WAIT_BUSY: if (!mgmt_busy) state_nx = ST_FETCH;
            ST_FETCH:
                if (cmd.kind == CK_END)
                    state_nx = (phase == PH_CONFIG) ? ST_PORT_RST : ST_DONE;
                else
                    state_nx = ST_XFER;
            ST_XFER:      if (mdio_ack) state_nx = ST_FETCH;
            ST_DONE:      state_nx = ST_IDLE;
        endcase
    end

    // sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_hi       <= '0;
            id_lo       <= '0;
            type_q      <= '0;
            phase       <= PH_CONFIG;
            step        <= '0;
            unsupported <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    unsupported <= 1'b0;
                    phase       <= PH_CONFIG;
                    step        <= '0;
                end
                ST_ID_HI: if (mdio_ack) id_hi <= mdio_rdata;
                ST_ID_LO: if (mdio_ack) id_lo <= mdio_rdata;
                ST_MATCH: begin
                    type_q <= type_hit;
                    if (!hit) unsupported <= 1'b1;
                end
                ST_FETCH: if (cmd.kind == CK_END && phase == PH_CONFIG) begin
                    phase <= PH_STARTUP;
                    step  <= '0;
                end
                ST_XFER: if (mdio_ack) step <= step + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mdio_req       = 1'b0;
        mdio_rw        = 1'b1;
        mdio_reg_addr  = '0;
        mdio_wdata     = '0;
        mgmt_cfg_reset = 1'b0;
        mgmt_cfg_init  = 1'b0;
        done           = 1'b0;
        unique case (state)
            ST_ID_HI: begin
                mdio_req      = 1'b1;
                mdio_reg_addr = REG_ID_HI;
            end
            ST_ID_LO: begin
                mdio_req      = 1'b1;
                mdio_reg_addr = REG_ID_LO;
            end
            ST_XFER: begin
                mdio_req      = 1'b1;
                mdio_rw       = (cmd.kind != CK_WRITE);
                mdio_reg_addr = cmd.reg_addr;
                mdio_wdata    = (cmd.kind == CK_WRITE) ? cmd.data : '0;
            end
            ST_PORT_RST:  mgmt_cfg_reset = 1'b1;
            ST_PORT_INIT: mgmt_cfg_init  = 1'b1;
            ST_DONE:      done           = 1'b1;
            default: ;
        endcase
    end

    assign clear    = (state == ST_IDLE) && start;
    assign ld_link  = (state == ST_XFER) && mdio_ack && (cmd.kind == CK_READ_LINK);
    assign ld_vstat = (state == ST_XFER) && mdio_ack && (cmd.kind == CK_READ_VSTAT);

    phy_status_decoder u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .ld_link     (ld_link),
        .link_bit    (mdio_rdata[STAT_LINK_BIT]),
        .ld_vstat    (ld_vstat),
        .vspd        (mdio_rdata[VSPD_HI:VSPD_LO]),
        .link_up     (link_up),
        .speed       (speed),
        .full_duplex (full_duplex)
    );

    // R5: request and its fields hold until acknowledged
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_reg_addr)
                                     && $stable(mdio_rw) && $stable(mdio_wdata)));

    // R4: init pulse follows the reset pulse directly
    p_init_follows_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_cfg_reset |=> (mgmt_cfg_init && !mgmt_cfg_reset));

    // R4: nothing is requested while the master reports busy in the wait
    p_no_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_busy && $past(mgmt_cfg_init)) |-> !mdio_req);

    // R3: an unsupported PHY gets no config pulses and no traffic
    p_unsup_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!mdio_req && !mgmt_cfg_reset && !done));

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/mdio_phy_sequencer_test.sv
module phy_mgmt_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rewind,
    input  logic        req,
    input  logic        rw,
    input  logic [4:0]  addr,
    input  logic        cfg_init,
    input  logic [15:0] id1,
    input  logic [15:0] id2,
    input  logic [15:0] stat_first,
    input  logic [15:0] stat_later,
    input  logic [15:0] vstat,
    input  logic [7:0]  busy_len,
    output logic        ack,
    output logic [15:0] rdata,
    output logic        busy
);
    logic [1:0] wait_cnt;
    logic [7:0] busy_left;
    logic [3:0] stat_reads;

    assign busy = (busy_left != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 0; rdata <= 0; wait_cnt <= 0; busy_left <= 0; stat_reads <= 0;
        end else begin
            if (rewind) stat_reads <= 0;
            if (cfg_init) busy_left <= busy_len;
            else if (busy_left != 0) busy_left <= busy_left - 1;
            if (ack) ack <= 0;
            else if (req) begin
                if (wait_cnt == 2) begin
                    ack <= 1; wait_cnt <= 0;
                    rdata <= 16'h0;
                    if (rw) begin
                        case (addr)
                            5'd1: begin
                                rdata <= (stat_reads == 0) ? stat_first : stat_later;
                                stat_reads <= stat_reads + 1;
                            end
                            5'd2:  rdata <= id1;
                            5'd3:  rdata <= id2;
                            5'd17: rdata <= vstat;
                            default: rdata <= 16'h0;
                        endcase
                    end
                end else wait_cnt <= wait_cnt + 1;
            end
        end
    end
endmodule

module mdio_phy_sequencer_test;
    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic cfg_reset, cfg_init, busy, req, rw, ack, done, unsup, link, dup;
    logic [4:0] addr;
    logic [15:0] wdata, rdata;
    logic [1:0] spd;
    logic rewind = 0;
    logic [15:0] m_id1 = 0, m_id2 = 0, m_sa = 0, m_sb = 0, m_vs = 0;
    logic [7:0] m_busy = 0;

    logic start2 = 0;
    logic cfg_reset2, cfg_init2, busy2, req2, rw2, ack2, done2, unsup2, link2, dup2;
    logic [4:0] addr2;
    logic [15:0] wdata2, rdata2;
    logic [1:0] spd2;

    int checks = 0;
    int errors = 0;
    int rst_pulses = 0;
    int done_pulses = 0;
    int rst_pulses2 = 0;
    int done_pulses2 = 0;
    int xacts2 = 0;

    logic [21:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    mdio_phy_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mgmt_cfg_reset(cfg_reset), .mgmt_cfg_init(cfg_init), .mgmt_busy(busy),
        .mdio_req(req), .mdio_rw(rw), .mdio_reg_addr(addr), .mdio_wdata(wdata),
        .mdio_ack(ack), .mdio_rdata(rdata), .done(done), .unsupported(unsup),
        .link_up(link), .speed(spd), .full_duplex(dup));

    phy_mgmt_model m0 (
        .clk(clk), .rst_n(rst_n), .rewind(rewind), .req(req), .rw(rw), .addr(addr),
        .cfg_init(cfg_init), .id1(m_id1), .id2(m_id2), .stat_first(m_sa),
        .stat_later(m_sb), .vstat(m_vs), .busy_len(m_busy),
        .ack(ack), .rdata(rdata), .busy(busy));

    mdio_phy_sequencer #(.GENERIC_EN(1'b0)) uut_nogen (
        .clk(clk), .rst_n(rst_n), .start(start2),
        .mgmt_cfg_reset(cfg_reset2), .mgmt_cfg_init(cfg_init2), .mgmt_busy(busy2),
        .mdio_req(req2), .mdio_rw(rw2), .mdio_reg_addr(addr2), .mdio_wdata(wdata2),
        .mdio_ack(ack2), .mdio_rdata(rdata2), .done(done2), .unsupported(unsup2),
        .link_up(link2), .speed(spd2), .full_duplex(dup2));

    phy_mgmt_model m1 (
        .clk(clk), .rst_n(rst_n), .rewind(1'b0), .req(req2), .rw(rw2), .addr(addr2),
        .cfg_init(cfg_init2), .id1(16'h1111), .id2(16'h2222), .stat_first(16'h0),
        .stat_later(16'h0), .vstat(16'h0), .busy_len(8'd0),
        .ack(ack2), .rdata(rdata2), .busy(busy2));

    task automatic chk(input bit ok, input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
        end
    endtask

    task automatic push(input bit r, input logic [4:0] a, input logic [15:0] d, input string t);
        exp_q.push_back({r, a, d});
        tag_q.push_back(t);
    endtask

    // scoreboard monitor for the main instance
    always @(negedge clk) begin
        if (rst_n && req && ack) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6", "unexpected transaction", {10'h0, rw, addr, wdata}, 32'h0);
            end else begin
                logic [21:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rw, addr, wdata} == e, t, "transaction {rw,addr,wdata}",
                    {10'h0, rw, addr, wdata}, {10'h0, e});
            end
        end
        if (rst_n && req && busy)
            chk(0, "R4", "request while busy", 32'h1, 32'h0);
        if (cfg_reset) rst_pulses++;
        if (done) done_pulses++;
        if (cfg_reset2) rst_pulses2++;
        if (done2) done_pulses2++;
        if (req2 && ack2) xacts2++;
    end

    task automatic expect_lists(input int ty);
        push(1, 5'd2, 16'h0, "R1");
        push(1, 5'd3, 16'h0, "R1");
        if (ty == 0) begin
            push(0, 5'd0, 16'h8000, "R6");
            push(0, 5'd16, 16'h0060, "R6");
            push(0, 5'd0, 16'h1200, "R6");
        end else if (ty == 1) begin
            push(0, 5'd0, 16'h1200, "R6");
        end else begin
            push(0, 5'd0, 16'h8000, "R6");
            push(0, 5'd0, 16'h1200, "R6");
        end
        push(1, 5'd1, 16'h0, "R7");
        push(1, 5'd1, 16'h0, "R7");
        push(1, (ty == 2) ? 5'd1 : 5'd17, 16'h0, "R7");
    endtask

    task automatic run_case(input string name, input logic [15:0] i1, input logic [15:0] i2,
                            input logic [15:0] sa, input logic [15:0] sb,
                            input logic [15:0] vs, input logic [7:0] bl, input int ty,
                            input bit e_link, input logic [1:0] e_spd, input bit e_dup,
                            input string st_tag);
        m_id1 = i1; m_id2 = i2; m_sa = sa; m_sb = sb; m_vs = vs; m_busy = bl;
        rewind = 1;
        @(negedge clk);
        rewind = 0;
        expect_lists(ty);
        rst_pulses = 0;
        done_pulses = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        chk(!link && spd == 2'b00 && !dup, "R11", {name, " status cleared by start"},
            {29'h0, link, spd}, 32'h0);
        for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
        chk(done, "R11", {name, " done pulse"}, {31'h0, done}, 32'h1);
        chk(exp_q.size() == 0, "R6", {name, " all expected transactions seen"},
            exp_q.size(), 32'h0);
        exp_q.delete();
        tag_q.delete();
        chk(rst_pulses == 2, "R4", {name, " config reset pulses"}, rst_pulses, 32'd2);
        chk(link == e_link, (st_tag == "R8") ? "R7" : st_tag, {name, " link_up"}, link, e_link);
        chk(spd == e_spd && dup == e_dup, st_tag, {name, " {speed,full_duplex}"},
            {29'h0, spd, dup}, {29'h0, e_spd, e_dup});
        repeat (4) @(negedge clk);
        chk(done_pulses == 1 && link == e_link && spd == e_spd && dup == e_dup, "R11",
            {name, " single done and held status"},
            {done_pulses[7:0], 20'h0, link, spd, dup}, {8'h1, 20'h0, e_link, e_spd, e_dup});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!req && !done && !unsup && !cfg_reset && !cfg_init, "R5", "reset outputs idle",
            {27'h0, req, done, unsup, cfg_reset, cfg_init}, 32'h0);
        chk(!link && spd == 0 && !dup, "R11", "reset status", {29'h0, link, spd}, 32'h0);

        // type 0, stale-down first read, 10 full, busy after init
        run_case("t0_10F", 16'h04A5, 16'hB3C7, 16'h0000, 16'h0004, 16'h4000, 8'd3, 0,
                 1, 2'b01, 1, "R8");
        // type 0, 100 half
        run_case("t0_100H", 16'h04A5, 16'hB3C1, 16'h0004, 16'h0004, 16'h8000, 8'd0, 0,
                 1, 2'b10, 0, "R8");
        // type 1, first read up but live link down; vendor field ignored
        run_case("t1_down", 16'h0030, 16'h3FC5, 16'h0004, 16'h0000, 16'hC000, 8'd2, 1,
                 0, 2'b00, 0, "R9");
        // type 1, 100 full
        run_case("t1_100F", 16'h0030, 16'h3FC5, 16'h0000, 16'h0004, 16'hC000, 8'd1, 1,
                 1, 2'b10, 1, "R8");
        // unknown identity falls to generic, no speed decode
        run_case("gen", 16'h1234, 16'h5678, 16'h0000, 16'h0004, 16'hC000, 8'd0, 2,
                 1, 2'b00, 0, "R10");
        // R2 near miss: one bit off type 0 goes generic
        run_case("near_miss", 16'h04A4, 16'hB3C7, 16'h0000, 16'h0004, 16'h4000, 8'd0, 2,
                 1, 2'b00, 0, "R2");
        // type 0, 10 half
        run_case("t0_10H", 16'h04A5, 16'hB3C0, 16'h0000, 16'h0004, 16'h0000, 8'd5, 0,
                 1, 2'b01, 0, "R8");

        // R3: no fallback and no match
        xacts2 = 0; rst_pulses2 = 0; done_pulses2 = 0;
        start2 = 1;
        @(negedge clk);
        start2 = 0;
        repeat (60) @(negedge clk);
        chk(unsup2, "R3", "unsupported raised", {31'h0, unsup2}, 32'h1);
        chk(xacts2 == 2, "R3", "only the two identity reads", xacts2, 32'd2);
        chk(rst_pulses2 == 0 && done_pulses2 == 0, "R3", "no config pulse and no done",
            {rst_pulses2[15:0], done_pulses2[15:0]}, 32'h0);
        start2 = 1;
        @(negedge clk);
        start2 = 0;
        chk(!unsup2, "R11", "start clears unsupported", {31'h0, unsup2}, 32'h0);
        repeat (60) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule